// File: doc/BRIEF.md
# Three-Channel Gamma Correction Table

This block applies a programmable gamma curve to the pixels of up to three display channels. Every channel owns one table per colour component: red, green and blue. Each table has one entry per input code. A pixel enters with its channel number and comes out corrected one clock later. The red, green and blue lookups happen in parallel, so the path accepts one pixel per cycle.

Software loads the tables through a single write port. It first writes an address register, which carries an auto-advance flag. It then streams entries through a data strobe. The flat address space is channel-major: within each channel the red table comes first, then green, then blue. A channel's tables therefore start at channel × 3 × 256.

Each channel has an enable bit. When the bit is clear, that channel's pixels pass through unchanged, which behaves like an identity curve. Tables may lose their contents while every channel is disabled, so software reloads them before enabling correction again.

Top module: `gamma_lut_ctrl`

## Requirements
- R1: Flat address A selects channel A / 768, component (A mod 768) / 256 (0 red, 1 green, 2 blue) and entry A mod 256.
- R2: A strobe on cfg_addr_we loads the address register with cfg_addr_val modulo 2304 and latches cfg_addr_inc as the auto-advance flag.
- R3: When the auto-advance flag is set, each data write stores cfg_data_val at the current address and then advances the address by one.
- R4: When the auto-advance flag is clear, consecutive data writes all land on the same address, and the last one wins.
- R5: Advancing from address 2303 wraps to address 0.
- R6: A valid pixel on an enabled channel below 3 returns table[channel][component][input] for all three components, exactly one cycle later.
- R7: A pixel on a channel whose enable bit is clear comes out equal to its input, one cycle later.
- R8: A pixel whose channel number is 3 or more passes through unchanged, whatever the enable bits are.
- R9: During and right after reset, out_vld is 0, all outputs are 0, and the address register is 0 with auto-advance off.
- R10: When the address strobe and the data strobe occur in the same cycle, the data goes to the old address, and the new address takes effect for the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_we | input | 1 | Load the address register |
| cfg_addr_val | input | 12 | Flat table address to load |
| cfg_addr_inc | input | 1 | Auto-advance flag loaded with the address |
| cfg_data_we | input | 1 | Write one table entry |
| cfg_data_val | input | 8 | Entry value |
| gamma_en | input | 3 | Per-channel correction enable |
| pix_vld | input | 1 | Input pixel valid |
| pix_chan | input | 2 | Channel of the input pixel |
| pix_r | input | 8 | Red input |
| pix_g | input | 8 | Green input |
| pix_b | input | 8 | Blue input |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 8 | Red output |
| out_g | output | 8 | Green output |
| out_b | output | 8 | Blue output |

## Verification
The assertions assume that every input is a known value at each clock edge. They also assume that a pixel never reads the entry being written in the same cycle: in that case the read returns the old contents, and no property constrains it. The stimulus changes inputs only on the falling edge. It finishes every table load before it sends any pixel, so reads and writes never meet on one entry. The pass-through check depends only on the enable bits present in the cycle the pixel is accepted, and the bench holds those bits steady around each pixel.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
   localparam int NCOL = 3;
   typedef enum logic [1:0] {COL_R = 2'd0, COL_G = 2'd1, COL_B = 2'd2} colour_e;
endpackage

// File: rtl/gamma_lut_wr_addr.sv
module gamma_lut_wr_addr #(
   parameter int NCH   = 3,
   parameter int DEPTH = 256,
   parameter int AW    = 12,
   parameter int CHW   = 2,
   parameter int IW    = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           addr_we,
   input  logic [AW-1:0]  addr_val,
   input  logic           addr_inc,
   input  logic           data_we,
   output logic [CHW-1:0] wr_chan,
   output logic [1:0]     wr_col,
   output logic [IW-1:0]  wr_idx
);
   import gamma_lut_pkg::*;
   localparam int CHSPAN = NCOL * DEPTH;
   localparam int TOTAL  = NCH * CHSPAN;

   logic [AW-1:0] addr_q;
   logic          inc_q;
   logic [31:0]   a32, rem32;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         inc_q  <= 1'b0;
      end else if (addr_we) begin
         addr_q <= AW'(32'(addr_val) % 32'(TOTAL));
         inc_q  <= addr_inc;
      end else if (data_we && inc_q) begin
         addr_q <= (32'(addr_q) == TOTAL - 1) ? '0 : addr_q + 1'b1;
      end
   end

   always_comb begin
      a32     = 32'(addr_q);
      rem32   = a32 % 32'(CHSPAN);
      wr_chan = CHW'(a32 / 32'(CHSPAN));
      wr_col  = 2'(rem32 / 32'(DEPTH));
      wr_idx  = IW'(rem32 % 32'(DEPTH));
   end

   AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(addr_q) < TOTAL); // R5
   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && inc_q && !addr_we) |=> 32'(addr_q) == (32'($past(addr_q)) + 1) % TOTAL); // R3
   AST_NO_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !inc_q && !addr_we) |=> $stable(addr_q)); // R4
endmodule

// File: rtl/gamma_lut_ram.sv
module gamma_lut_ram #(
   parameter int DW  = 8,
   parameter int NCH = 3
) (
   input  logic           clk,
   input  logic           we,
   input  logic [$clog2(NCH*(1<<DW))-1:0] waddr,
   input  logic [DW-1:0]  wdata,
   input  logic [$clog2(NCH*(1<<DW))-1:0] raddr,
   output logic [DW-1:0]  rdata
);
   localparam int WORDS = NCH * (1 << DW);

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl #(
   parameter int NCH = 3,
   parameter int DW  = 8,
   localparam int DEPTH = 1 << DW,
   localparam int AW    = $clog2(NCH * 3 * DEPTH),
   localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_addr_we,
   input  logic [AW-1:0]  cfg_addr_val,
   input  logic           cfg_addr_inc,
   input  logic           cfg_data_we,
   input  logic [DW-1:0]  cfg_data_val,
   input  logic [NCH-1:0] gamma_en,
   input  logic           pix_vld,
   input  logic [CHW-1:0] pix_chan,
   input  logic [DW-1:0]  pix_r,
   input  logic [DW-1:0]  pix_g,
   input  logic [DW-1:0]  pix_b,
   output logic           out_vld,
   output logic [DW-1:0]  out_r,
   output logic [DW-1:0]  out_g,
   output logic [DW-1:0]  out_b
);
   import gamma_lut_pkg::*;
   localparam int RAW = $clog2(NCH * DEPTH);
   localparam int ENW = 1 << CHW;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("gamma_lut_ctrl: NCH out of range");
   end
   if (DW < 2 || DW > 10) begin : g_bad_dw
      $error("gamma_lut_ctrl: DW out of range");
   end

   logic [CHW-1:0] wr_chan;
   logic [1:0]     wr_col;
   logic [DW-1:0]  wr_idx;
   logic [RAW-1:0] waddr;
   logic [ENW-1:0] en_ext;
   logic           chan_ok, use_lut;
   logic [NCOL-1:0] col_we;
   logic [DW-1:0]  pin  [NCOL];
   logic [DW-1:0]  pout [NCOL];
   logic [DW-1:0]  lut_q [NCOL];
   logic [DW-1:0]  byp_q [NCOL];
   logic           sel_lut_q, vld_q;

   gamma_lut_wr_addr #(
      .NCH(NCH), .DEPTH(DEPTH), .AW(AW), .CHW(CHW), .IW(DW)
   ) u_wr_addr (
      .clk(clk), .rst_n(rst_n),
      .addr_we(cfg_addr_we), .addr_val(cfg_addr_val), .addr_inc(cfg_addr_inc),
      .data_we(cfg_data_we),
      .wr_chan(wr_chan), .wr_col(wr_col), .wr_idx(wr_idx)
   );

   always_comb begin
      en_ext = '0;
      en_ext[NCH-1:0] = gamma_en;
      chan_ok = 32'(pix_chan) < NCH;
      use_lut = chan_ok && en_ext[pix_chan];
      waddr   = RAW'(32'(wr_chan) * DEPTH + 32'(wr_idx));
   end

   assign pin[0] = pix_r;
   assign pin[1] = pix_g;
   assign pin[2] = pix_b;

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      logic [RAW-1:0] raddr;
      assign col_we[c] = cfg_data_we && (wr_col == 2'(c));
      assign raddr = chan_ok ? RAW'(32'(pix_chan) * DEPTH + 32'(pin[c])) : '0;

      gamma_lut_ram #(.DW(DW), .NCH(NCH)) u_ram (
         .clk(clk), .we(col_we[c]), .waddr(waddr), .wdata(cfg_data_val),
         .raddr(raddr), .rdata(lut_q[c])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) byp_q[c] <= '0;
         else        byp_q[c] <= pin[c];
      end

      assign pout[c] = sel_lut_q ? lut_q[c] : byp_q[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_lut_q <= 1'b0;
         vld_q     <= 1'b0;
      end else begin
         sel_lut_q <= pix_vld && use_lut;
         vld_q     <= pix_vld;
      end
   end

   assign out_vld = vld_q;
   assign out_r   = pout[0];
   assign out_g   = pout[1];
   assign out_b   = pout[2];

   AST_ONE_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_we)); // R1
   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && !use_lut) |=> (out_r == $past(pix_r) && out_g == $past(pix_g)
                                && out_b == $past(pix_b))); // R7
   AST_WIDE_CHAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && !chan_ok) |=> (out_r == $past(pix_r) && out_b == $past(pix_b))); // R8
   AST_VALID_AFTER_PIX: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld |=> out_vld); // R6
endmodule

// File: tb/gamma_lut_ctrl_tb.sv
module gamma_lut_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_addr_we = 1'b0;
   logic [11:0] cfg_addr_val = '0;
   logic        cfg_addr_inc = 1'b0;
   logic        cfg_data_we = 1'b0;
   logic [7:0]  cfg_data_val = '0;
   logic [2:0]  gamma_en = '0;
   logic        pix_vld = 1'b0;
   logic [1:0]  pix_chan = '0;
   logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
   logic        out_vld;
   logic [7:0]  out_r, out_g, out_b;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gamma_lut_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_addr_we(cfg_addr_we), .cfg_addr_val(cfg_addr_val), .cfg_addr_inc(cfg_addr_inc),
      .cfg_data_we(cfg_data_we), .cfg_data_val(cfg_data_val),
      .gamma_en(gamma_en),
      .pix_vld(pix_vld), .pix_chan(pix_chan), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   // {enable[2:0], channel[1:0], r, g, b}
   localparam logic [28:0] VEC [8] = '{
      {3'b111, 2'd0, 8'h00, 8'h80, 8'hFF},
      {3'b111, 2'd1, 8'h12, 8'h34, 8'h56},
      {3'b111, 2'd2, 8'hFF, 8'h00, 8'h7F},
      {3'b010, 2'd1, 8'hA5, 8'h5A, 8'h3C},
      {3'b101, 2'd1, 8'hA5, 8'h5A, 8'h3C},
      {3'b011, 2'd2, 8'h01, 8'h02, 8'h03},
      {3'b111, 2'd3, 8'h09, 8'h08, 8'h07},
      {3'b100, 2'd2, 8'h10, 8'h20, 8'h30}
   };

   function automatic logic [7:0] fill_val(int a);
      return 8'((a * 13 + (a >> 8) * 5 + 1) % 256);
   endfunction

   task automatic chk(string req, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic set_addr(int v, bit inc);
      cfg_addr_we = 1'b1; cfg_addr_val = 12'(v); cfg_addr_inc = inc;
      @(negedge clk);
      cfg_addr_we = 1'b0;
   endtask

   task automatic wr_data(logic [7:0] v);
      cfg_data_we = 1'b1; cfg_data_val = v;
      @(negedge clk);
      cfg_data_we = 1'b0;
   endtask

   task automatic look(logic [2:0] en, logic [1:0] ch, logic [7:0] r, logic [7:0] g, logic [7:0] b);
      gamma_en = en; pix_vld = 1'b1; pix_chan = ch; pix_r = r; pix_g = g; pix_b = b;
      @(negedge clk);
      pix_vld = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 out_vld", out_vld, 0);
      chk("R9 out_r", out_r, 0);
      chk("R9 out_b", out_b, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 out_vld after release", out_vld, 0);
      // R9: address resets to 0 with auto-advance off, so two writes hit entry 0
      wr_data(8'hC1);
      wr_data(8'hC2);
      look(3'b001, 2'd0, 8'h00, 8'h00, 8'h00);
      chk("R9 reset address and flag", out_r, 8'hC2);

      // Fill all tables through auto-advance (R1, R3)
      set_addr(0, 1'b1);
      for (int a = 0; a < 2304; a++) wr_data(fill_val(a));

      // Vector table walk: R1, R6, R7, R8
      for (int i = 0; i < 8; i++) begin
         logic [2:0] en;
         logic [1:0] ch;
         logic [7:0] vin [3];
         int exp_c [3];
         bit lut;
         en = VEC[i][28:26]; ch = VEC[i][25:24];
         vin[0] = VEC[i][23:16]; vin[1] = VEC[i][15:8]; vin[2] = VEC[i][7:0];
         lut = (ch < 3) && en[ch];
         for (int c = 0; c < 3; c++)
            exp_c[c] = lut ? int'(fill_val(int'(ch) * 768 + c * 256 + int'(vin[c]))) : int'(vin[c]);
         look(en, ch, vin[0], vin[1], vin[2]);
         if (lut) begin
            chk("R6 R1 red", out_r, exp_c[0]);
            chk("R6 R1 green", out_g, exp_c[1]);
            chk("R6 R1 blue", out_b, exp_c[2]);
         end else if (ch >= 3) begin
            chk("R8 red", out_r, exp_c[0]);
            chk("R8 green", out_g, exp_c[1]);
            chk("R8 blue", out_b, exp_c[2]);
         end else begin
            chk("R7 red", out_r, exp_c[0]);
            chk("R7 green", out_g, exp_c[1]);
            chk("R7 blue", out_b, exp_c[2]);
         end
         chk("R6 valid latency", out_vld, 1);
      end
      @(negedge clk);
      chk("R6 valid drops", out_vld, 0);

      // R5: wrap from last address to 0
      set_addr(2303, 1'b1);
      wr_data(8'hAA);
      wr_data(8'hBB);
      look(3'b111, 2'd2, 8'h00, 8'h00, 8'hFF);
      chk("R5 last entry", out_b, 8'hAA);
      look(3'b111, 2'd0, 8'h00, 8'h00, 8'h00);
      chk("R5 wrapped to 0", out_r, 8'hBB);

      // R4: no auto-advance
      set_addr(1029, 1'b0);
      wr_data(8'h11);
      wr_data(8'h22);
      wr_data(8'h33);
      look(3'b111, 2'd1, 8'h00, 8'h05, 8'h00);
      chk("R4 last write wins", out_g, 8'h33);
      look(3'b111, 2'd1, 8'h00, 8'h06, 8'h00);
      chk("R4 neighbour untouched", out_g, fill_val(1030));

      // R10: simultaneous address and data strobes
      cfg_addr_we = 1'b1; cfg_addr_val = 12'd1546; cfg_addr_inc = 1'b0;
      cfg_data_we = 1'b1; cfg_data_val = 8'h44;
      @(negedge clk);
      cfg_addr_we = 1'b0; cfg_data_we = 1'b0;
      wr_data(8'h55);
      look(3'b111, 2'd1, 8'h00, 8'h05, 8'h00);
      chk("R10 data to old address", out_g, 8'h44);
      look(3'b111, 2'd2, 8'h0A, 8'h00, 8'h00);
      chk("R10 new address next", out_r, 8'h55);

      // R2: loaded address reduced modulo 2304
      set_addr(2311, 1'b0);
      wr_data(8'h66);
      look(3'b111, 2'd0, 8'h07, 8'h00, 8'h00);
      chk("R2 modulo load", out_r, 8'h66);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule